// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This unit sits between an 8-bit core's instruction decoder and its data RAM. For every register-file operand it produces a 9-bit RAM address, a read strobe and a write strobe, and it hands the RAM read data back to the core. There are two ways to form the address. In direct mode, two bank-select bits sit above the 7-bit operand field of the instruction. In pointer mode, a single indirect bank bit sits above an 8-bit file-select pointer.

Pointer mode is chosen whenever the operand field names the indirect-access register, which is code 0x00. One case is guarded: the pointer's low 7 bits may be 0x00 in either bank, so the pointer aims at the indirect register itself. A read in that case returns 0x00, and a write does nothing. In both cases the RAM strobes stay low.

All outputs are combinational, so they are valid in the same cycle as the instruction field and register values that produce them. Internally, every access is sorted into one of three named kinds: DIRECT, POINTER and SELF. One case statement over that kind drives the strobes and the returned data. The kind follows from the inputs alone and holds no state, so there are no transitions between kinds.

Top module: `bank_addr_unit`

## Requirements
- R1: When the operand field is not 0x00, the address is {bank_sel[1:0], op_field[6:0]} (bank_sel in bits 8:7). The pointer and the indirect bank bit have no effect on it.
- R2: When the operand field is 0x00, the address is {ind_bank, ptr[7:0]} (ind_bank in bit 8). The bank-select bits have no effect on it.
- R3: In direct mode, ram_re follows rd_req, ram_we follows wr_req, and rdata equals ram_rdata.
- R4: In pointer mode, when ptr[6:0] is not 0x00, ram_re follows rd_req, ram_we follows wr_req, and rdata equals ram_rdata.
- R5: In pointer mode, when ptr[6:0] is 0x00, rdata is 0x00 and ram_re is 0. This holds whatever the values of ptr[7] and ind_bank.
- R6: In pointer mode, when ptr[6:0] is 0x00, ram_we is 0 even when wr_req is 1.
- R7: When neither rd_req nor wr_req is high, both ram_re and ram_we are 0.
- R8: A change on any input shows up on the outputs in the same clock cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_field | input | 7 | File operand field of the current instruction |
| bank_sel | input | 2 | Direct-mode bank-select bits |
| ind_bank | input | 1 | Pointer-mode bank bit |
| ptr | input | 8 | File-select pointer value |
| rd_req | input | 1 | Core requests a register-file read |
| wr_req | input | 1 | Core requests a register-file write |
| ram_rdata | input | 8 | Data returned by the RAM |
| ram_addr | output | 9 | Data RAM address |
| ram_re | output | 1 | Data RAM read enable |
| ram_we | output | 1 | Data RAM write enable |
| rdata | output | 8 | Read data returned to the core |

## Verification
The bench builds the unit with its default parameters: a 7-bit operand field, an 8-bit pointer, two bank bits and 8-bit data. With these values every corner of the 9-bit address can be reached, including 0x000 and 0x1FF. Under these defaults the self-reference case can be hit with the pointer's top bit clear or set and with either indirect bank bit. The bench also covers the near misses: a pointer of 0x01, and a direct operand while the pointer holds 0x00.

// File: rtl/bau_pkg.sv
`timescale 1ns/1ps
package bau_pkg;
    localparam int OP_W_DEF   = 7;
    localparam int PTR_W_DEF  = 8;
    localparam int BANK_W_DEF = 2;
    localparam int DATA_W_DEF = 8;

    typedef enum logic [1:0] {
        ACC_DIRECT  = 2'd0,
        ACC_POINTER = 2'd1,
        ACC_SELF    = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/bau_classify.sv
`timescale 1ns/1ps
module bau_classify #(
    parameter int OP_W     = bau_pkg::OP_W_DEF,
    parameter int PTR_W    = bau_pkg::PTR_W_DEF,
    parameter int IND_CODE = 0
) (
    input  logic [OP_W-1:0]   op_field,
    input  logic [PTR_W-1:0]  ptr,
    output bau_pkg::acc_kind_e kind
);
    logic names_indirect;
    logic ptr_is_self;

    assign names_indirect = (op_field == OP_W'(IND_CODE));
    assign ptr_is_self    = (ptr[OP_W-1:0] == OP_W'(IND_CODE));

    always_comb begin
        if (!names_indirect) begin
            kind = bau_pkg::ACC_DIRECT;
        end else if (ptr_is_self) begin
            kind = bau_pkg::ACC_SELF;
        end else begin
            kind = bau_pkg::ACC_POINTER;
        end
    end
endmodule

// File: rtl/bau_addr_mux.sv
`timescale 1ns/1ps
module bau_addr_mux #(
    parameter int OP_W   = bau_pkg::OP_W_DEF,
    parameter int PTR_W  = bau_pkg::PTR_W_DEF,
    parameter int BANK_W = bau_pkg::BANK_W_DEF,
    localparam int ADDR_W = BANK_W + OP_W,
    localparam int IBK_W  = ADDR_W - PTR_W
) (
    input  bau_pkg::acc_kind_e kind,
    input  logic [OP_W-1:0]    op_field,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic [IBK_W-1:0]   ind_bank,
    input  logic [PTR_W-1:0]   ptr,
    output logic [ADDR_W-1:0]  addr
);
    logic [ADDR_W-1:0] direct_addr;
    logic [ADDR_W-1:0] pointer_addr;
    logic              use_pointer;

    assign direct_addr  = {bank_sel, op_field};
    assign pointer_addr = {ind_bank, ptr};
    assign use_pointer  = (kind != bau_pkg::ACC_DIRECT);

    for (genvar b = 0; b < ADDR_W; b++) begin : g_addr_bit
        assign addr[b] = use_pointer ? pointer_addr[b] : direct_addr[b];
    end
endmodule

// File: rtl/bau_access_gate.sv
`timescale 1ns/1ps
module bau_access_gate #(
    parameter int DATA_W = bau_pkg::DATA_W_DEF
) (
    input  bau_pkg::acc_kind_e kind,
    input  logic               rd_req,
    input  logic               wr_req,
    input  logic [DATA_W-1:0]  ram_rdata,
    output logic               ram_re,
    output logic               ram_we,
    output logic [DATA_W-1:0]  rdata
);
    always_comb begin
        unique case (kind)
            bau_pkg::ACC_DIRECT,
            bau_pkg::ACC_POINTER: begin
                ram_re = rd_req;
                ram_we = wr_req;
                rdata  = ram_rdata;
            end
            bau_pkg::ACC_SELF: begin
                ram_re = 1'b0;
                ram_we = 1'b0;
                rdata  = '0;
            end
            default: begin
                ram_re = 1'b0;
                ram_we = 1'b0;
                rdata  = '0;
            end
        endcase
    end
endmodule

// File: rtl/bank_addr_unit.sv
`timescale 1ns/1ps
module bank_addr_unit #(
    parameter int OP_W     = bau_pkg::OP_W_DEF,
    parameter int PTR_W    = bau_pkg::PTR_W_DEF,
    parameter int BANK_W   = bau_pkg::BANK_W_DEF,
    parameter int DATA_W   = bau_pkg::DATA_W_DEF,
    parameter int IND_CODE = 0,
    localparam int ADDR_W  = BANK_W + OP_W,
    localparam int IBK_W   = ADDR_W - PTR_W
) (
    input  logic [OP_W-1:0]   op_field,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [IBK_W-1:0]  ind_bank,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic [DATA_W-1:0] rdata
);
    bau_pkg::acc_kind_e kind;

    bau_classify #(
        .OP_W     (OP_W),
        .PTR_W    (PTR_W),
        .IND_CODE (IND_CODE)
    ) u_classify (
        .op_field (op_field),
        .ptr      (ptr),
        .kind     (kind)
    );

    bau_addr_mux #(
        .OP_W   (OP_W),
        .PTR_W  (PTR_W),
        .BANK_W (BANK_W)
    ) u_addr_mux (
        .kind     (kind),
        .op_field (op_field),
        .bank_sel (bank_sel),
        .ind_bank (ind_bank),
        .ptr      (ptr),
        .addr     (ram_addr)
    );

    bau_access_gate #(
        .DATA_W (DATA_W)
    ) u_gate (
        .kind      (kind),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .ram_rdata (ram_rdata),
        .ram_re    (ram_re),
        .ram_we    (ram_we),
        .rdata     (rdata)
    );

    always_comb begin
        if (op_field != OP_W'(IND_CODE))
            AST_DIRECT_ADDR: assert (ram_addr == {bank_sel, op_field}); // R1
        if (op_field == OP_W'(IND_CODE))
            AST_POINTER_ADDR: assert (ram_addr == {ind_bank, ptr}); // R2
        if (op_field == OP_W'(IND_CODE) && ptr[OP_W-1:0] == OP_W'(IND_CODE))
            AST_SELF_READ_ZERO: assert (rdata == '0 && !ram_re); // R5
        if (op_field == OP_W'(IND_CODE) && ptr[OP_W-1:0] == OP_W'(IND_CODE))
            AST_SELF_NO_WRITE: assert (!ram_we); // R6
        if (!rd_req && !wr_req)
            AST_IDLE_QUIET: assert (!ram_re && !ram_we); // R7
    end
endmodule

// File: tb/bank_addr_unit_test.sv
`timescale 1ns/1ps
module bank_addr_unit_test;
    logic       clk = 1'b0;
    logic [6:0] op_field = '0;
    logic [1:0] bank_sel = '0;
    logic       ind_bank = 1'b0;
    logic [7:0] ptr = '0;
    logic       rd_req = 1'b0;
    logic       wr_req = 1'b0;
    logic [7:0] ram_rdata = '0;
    logic [8:0] ram_addr;
    logic       ram_re;
    logic       ram_we;
    logic [7:0] rdata;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic [8:0] addr;
        logic       re;
        logic       we;
        logic [7:0] data;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    bank_addr_unit uut (
        .op_field  (op_field),
        .bank_sel  (bank_sel),
        .ind_bank  (ind_bank),
        .ptr       (ptr),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .ram_re    (ram_re),
        .ram_we    (ram_we),
        .rdata     (rdata)
    );

    task automatic apply(input logic [6:0] op, input logic [1:0] bk, input logic ib,
                         input logic [7:0] p, input logic rd, input logic wr,
                         input logic [7:0] rd_data, input string tag);
        exp_t e;
        logic self_ref;
        @(posedge clk);
        #1;
        op_field  = op;
        bank_sel  = bk;
        ind_bank  = ib;
        ptr       = p;
        rd_req    = rd;
        wr_req    = wr;
        ram_rdata = rd_data;
        self_ref  = (op == 7'h00) && (p[6:0] == 7'h00);
        e.addr = (op != 7'h00) ? {bk, op} : {ib, p};
        e.re   = self_ref ? 1'b0 : rd;
        e.we   = self_ref ? 1'b0 : wr;
        e.data = self_ref ? 8'h00 : rd_data;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic check(input string tag, input string field, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, field, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "ram_addr", int'(ram_addr), int'(e.addr));
            check(e.tag, "ram_re", int'(ram_re), int'(e.re));
            check(e.tag, "ram_we", int'(ram_we), int'(e.we));
            check(e.tag, "rdata", int'(rdata), int'(e.data));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // idle state after start: no strobes (R7)
        apply(7'h00, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R7 idle start");
        apply(7'h25, 2'd2, 1'b1, 8'h44, 1'b0, 1'b0, 8'h9C, "R7 idle direct");
        // direct addressing over every bank, pointer ignored (R1, R3)
        for (int b = 0; b < 4; b++) begin
            apply(7'h25, 2'(b), 1'b1, 8'hA5, 1'b1, 1'b0, 8'(8'h30 + b), "R1 R3 direct read");
            apply(7'h5A, 2'(b), 1'b0, 8'h00, 1'b0, 1'b1, 8'h11, "R1 R3 direct write ptr zero");
        end
        apply(7'h7F, 2'd3, 1'b0, 8'h12, 1'b1, 1'b0, 8'hEE, "R1 top address");
        apply(7'h01, 2'd0, 1'b1, 8'h80, 1'b1, 1'b1, 8'h55, "R1 R3 low address");
        // pointer mode, bank bits ignored (R2, R4)
        apply(7'h00, 2'd3, 1'b1, 8'hA5, 1'b1, 1'b0, 8'h77, "R2 R4 pointer read");
        apply(7'h00, 2'd1, 1'b0, 8'hFF, 1'b0, 1'b1, 8'h66, "R2 R4 pointer write");
        apply(7'h00, 2'd2, 1'b1, 8'hFF, 1'b1, 1'b0, 8'hC3, "R2 R4 pointer top");
        apply(7'h00, 2'd0, 1'b0, 8'h01, 1'b1, 1'b1, 8'h3C, "R2 R4 pointer near self");
        apply(7'h00, 2'd0, 1'b1, 8'h81, 1'b1, 1'b0, 8'h5A, "R2 R4 pointer near self upper");
        // self reference in all bank and top-bit combinations (R5, R6)
        for (int k = 0; k < 4; k++) begin
            apply(7'h00, 2'd1, k[0], {k[1], 7'h00}, 1'b1, 1'b0, 8'hDE, "R5 self read");
            apply(7'h00, 2'd2, k[0], {k[1], 7'h00}, 1'b0, 1'b1, 8'hAD, "R6 self write");
        end
        // back-to-back input changes seen in the same cycle (R8)
        apply(7'h33, 2'd1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h01, "R8 same cycle a");
        apply(7'h00, 2'd1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h02, "R8 same cycle b");
        apply(7'h00, 2'd1, 1'b1, 8'h42, 1'b1, 1'b1, 8'h03, "R8 same cycle c");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule